// File: doc/BRIEF.md
# Pushbutton Up/Down Position Controller

This block sets the tap of a 64-position digital potentiometer from two active-low control lines, one that raises the tap and one that lowers it. The lines may come straight from contact-closure pushbuttons or from a processor. The block times each low pulse and each high interval between pulses. A press of moderate length moves the tap by one. A press held longer starts auto-repeat at a fixed rate. Pulses that are too brief, or that follow too short a high interval, are dropped. This also filters out contact bounce, so no external debounce is needed.

A storage controller can freeze the block with a suspend input while it writes the tap to non-volatile cells. It can also load a restored tap value at any time. For a period after reset the control lines are locked out. A press that is already held when the lockout ends must be released before it can take effect. All time thresholds are given in clock cycles and are derived from the `CLK_HZ` parameter: 1 ms for the minimum press and the minimum gap, 0.5 s for the hold threshold, 100 ms for the repeat period and 10 ms for the lockout.

Top module: `updown_wiper`

## Requirements
- R1: After reset the tap output equals the INIT_POS parameter (default 32).
- R2: For T_LOCK cycles after reset the control inputs have no effect. A press that begins inside that window causes no step, even if it is held past the end of the window.
- R3: A press (input low) lasting at least T_MIN and less than T_HOLD + T_REP cycles changes the tap by exactly one step. up_n increments the tap and down_n decrements it.
- R4: A press shorter than T_MIN cycles leaves the tap unchanged.
- R5: A press that follows a high interval shorter than T_GAP cycles is ignored in full. A press that follows a longer interval is accepted.
- R6: While a press is held, the tap steps again after T_HOLD + T_REP low cycles and then once every further T_REP cycles. No repeat step occurs before that point.
- R7: The tap saturates at 63 when incrementing and at 0 when decrementing. At an end, further presses in the same direction have no effect, and a press in the opposite direction moves it away.
- R8: While both inputs are low together, neither direction acts. No step occurs until both inputs have been high at the same time, even if one of them stays low alone for a long time.
- R9: While suspend is high, press timing and stepping are frozen and the tap does not move. When suspend falls, a press that is still held continues counting from where it stopped.
- R10: When load_en is high on a clock edge, the tap takes the value of load_pos on that edge. This happens regardless of suspend and takes precedence over any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Active-low increment control, asynchronous to clk |
| down_n | input | 1 | Active-low decrement control, asynchronous to clk |
| suspend | input | 1 | High while the storage logic is busy; freezes the controller |
| load_en | input | 1 | Loads load_pos into the tap |
| load_pos | input | POS_W | Restored tap value |
| pos | output | POS_W | Current tap position |

## Verification
The bench builds the block with CLK_HZ = 4000. This gives a 4-cycle minimum press and minimum gap, a 40-cycle lockout, a 2000-cycle hold threshold and a 400-cycle repeat period. At these values, holds of several repeat periods, travel into both ends, and a long suspend in the middle of a hold all fit in a short run. The thresholds stay far enough apart that each press length can be placed clearly on one side of a boundary, even after the two-cycle synchronizer delay.

// File: rtl/updown_wiper.sv
module updown_wiper #(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned INIT_POS = 32,
  parameter int unsigned T_MIN    = CLK_HZ / 1000,
  parameter int unsigned T_GAP    = CLK_HZ / 1000,
  parameter int unsigned T_HOLD   = CLK_HZ / 2,
  parameter int unsigned T_REP    = CLK_HZ / 10,
  parameter int unsigned T_LOCK   = CLK_HZ / 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n,
  input  logic             down_n,
  input  logic             suspend,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_pos,
  output logic [POS_W-1:0] pos
);
  localparam int unsigned CW = $clog2(T_HOLD + 1);
  localparam int unsigned RW = $clog2(T_REP + 1);
  localparam int unsigned GW = $clog2(T_GAP + 1);
  localparam int unsigned LW = $clog2(T_LOCK + 1);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

  typedef enum logic [1:0] {IDLE, PRESS, BLOCK} st_t;

  logic [1:0] up_sy, dn_sy;
  st_t        st;
  logic       dir_up, step;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rep;
  logic [GW-1:0] gap;
  logic [LW-1:0] lock;

  wire up_l      = !up_sy[1];
  wire dn_l      = !dn_sy[1];
  wire own_l     = dir_up ? up_l : dn_l;
  wire other_l   = dir_up ? dn_l : up_l;
  wire lock_done = (lock == LW'(T_LOCK));
  wire gap_ok    = (gap == GW'(T_GAP));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_sy <= 2'b11;
      dn_sy <= 2'b11;
    end else begin
      up_sy <= {up_sy[0], up_n};
      dn_sy <= {dn_sy[0], down_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock <= '0;
    else if (!lock_done) lock <= lock + 1'b1;

  always_comb begin
    step = 1'b0;
    if (!suspend && st == PRESS && own_l && !other_l) begin
      if (cnt < CW'(T_HOLD)) step = (cnt == CW'(T_MIN - 1));
      else                   step = (rep == RW'(T_REP - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      dir_up <= 1'b0;
      cnt    <= '0;
      rep    <= '0;
      gap    <= GW'(T_GAP);
    end else if (!suspend) begin
      case (st)
        IDLE:
          if (up_l || dn_l) begin
            st     <= ((up_l && dn_l) || !lock_done || !gap_ok) ? BLOCK : PRESS;
            dir_up <= up_l;
            cnt    <= CW'(1);
            rep    <= '0;
          end else if (!gap_ok) begin
            gap <= gap + 1'b1;
          end
        PRESS:
          if (!own_l) begin
            st  <= other_l ? BLOCK : IDLE;
            gap <= GW'(1);
          end else if (other_l) begin
            st <= BLOCK;
          end else if (cnt < CW'(T_HOLD)) begin
            cnt <= cnt + 1'b1;
          end else begin
            rep <= (rep == RW'(T_REP - 1)) ? '0 : rep + 1'b1;
          end
        default:
          if (!up_l && !dn_l) begin
            st  <= IDLE;
            gap <= GW'(1);
          end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pos <= POS_W'(INIT_POS);
    else if (load_en) pos <= load_pos;
    else if (step) begin
      if (dir_up && pos != TOP)       pos <= pos + 1'b1;
      else if (!dir_up && pos != '0)  pos <= pos - 1'b1;
    end

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pos == $past(load_pos));
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (pos == $past(pos) || pos == $past(pos) + POS_W'(1)
                  || pos == $past(pos) - POS_W'(1)));
  p_no_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && pos == TOP) |=> pos != '0);
  p_no_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && pos == '0) |=> pos != TOP);
  p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_done && !load_en) |=> $stable(pos));
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && !load_en) |=> $stable(pos));
  p_both_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_l && dn_l && !load_en) |=> $stable(pos));
endmodule

// File: tb/updown_wiper_test.sv
module updown_wiper_test;
  localparam int unsigned HZ   = 4000;
  localparam int unsigned HOLD = HZ / 2;
  localparam int unsigned REP  = HZ / 10;

  logic clk = 1'b0, rst_n = 1'b0, up_n = 1'b1, down_n = 1'b1;
  logic suspend = 1'b0, load_en = 1'b0;
  logic [5:0] load_pos = '0;
  logic [5:0] pos;
  int checks = 0, errors = 0;
  bit done = 0;
  int exp_q[$];
  string req_q[$];
  logic [5:0] last;

  always #2 clk = ~clk;

  updown_wiper #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .down_n(down_n),
    .suspend(suspend), .load_en(load_en), .load_pos(load_pos), .pos(pos));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pos(input int v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic press(input bit up, input int n);
    if (up) up_n = 1'b0; else down_n = 1'b0;
    tick(n);
    up_n = 1'b1;
    down_n = 1'b1;
  endtask

  task automatic load(input int v);
    expect_pos(v, "R10");
    load_pos = 6'(v);
    load_en = 1'b1;
    tick(1);
    load_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) last = pos;
    else if (pos !== last) begin
      if (exp_q.size() == 0) check(0, "R3/R9 unexpected move", int'(pos), int'(last));
      else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(int'(pos) == e, r, int'(pos), e);
      end
      last = pos;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(1);
    check(pos == 6'd32, "R1", pos, 32);

    tick(2);
    press(1, 60);
    tick(20);
    check(pos == 6'd32, "R2", pos, 32);

    expect_pos(33, "R3");
    press(1, 10);
    tick(20);
    expect_pos(32, "R3");
    press(0, 10);
    tick(20);
    check(pos == 6'd32, "R3", pos, 32);

    press(1, 3);
    tick(20);
    check(pos == 6'd32, "R4", pos, 32);

    expect_pos(33, "R5");
    press(1, 10);
    tick(2);
    press(1, 10);
    tick(20);
    check(pos == 6'd33, "R5", pos, 33);
    expect_pos(34, "R5");
    press(1, 10);
    tick(20);
    check(pos == 6'd34, "R5", pos, 34);

    load(20);
    tick(5);
    expect_pos(21, "R6");
    up_n = 1'b0;
    tick(HOLD + REP - 50);
    check(pos == 6'd21, "R6", pos, 21);
    expect_pos(22, "R6");
    expect_pos(23, "R6");
    expect_pos(24, "R6");
    tick(2 * REP + 200);
    up_n = 1'b1;
    tick(20);
    check(pos == 6'd24, "R6", pos, 24);

    load(60);
    tick(5);
    expect_pos(61, "R7");
    expect_pos(62, "R7");
    expect_pos(63, "R7");
    press(1, HOLD + 6 * REP + 200);
    tick(20);
    press(1, 10);
    tick(20);
    check(pos == 6'd63, "R7", pos, 63);
    expect_pos(62, "R7");
    press(0, 10);
    tick(20);
    load(1);
    tick(5);
    expect_pos(0, "R7");
    press(0, 10);
    tick(20);
    press(0, 10);
    tick(20);
    check(pos == 6'd0, "R7", pos, 0);

    up_n = 1'b0;
    down_n = 1'b0;
    tick(20);
    up_n = 1'b1;
    down_n = 1'b1;
    tick(20);
    up_n = 1'b0;
    tick(2);
    down_n = 1'b0;
    tick(20);
    down_n = 1'b1;
    tick(30);
    up_n = 1'b1;
    tick(20);
    check(pos == 6'd0, "R8", pos, 0);
    expect_pos(1, "R8");
    press(1, 10);
    tick(20);
    check(pos == 6'd1, "R8", pos, 1);

    load(10);
    tick(5);
    expect_pos(11, "R9");
    up_n = 1'b0;
    tick(HOLD - 500);
    suspend = 1'b1;
    tick(3000);
    check(pos == 6'd11, "R9", pos, 11);
    suspend = 1'b0;
    expect_pos(12, "R9");
    expect_pos(13, "R9");
    tick(1500);
    up_n = 1'b1;
    tick(20);
    check(pos == 6'd13, "R9", pos, 13);

    suspend = 1'b1;
    tick(2);
    load(45);
    suspend = 1'b0;
    tick(2);
    check(pos == 6'd45, "R10", pos, 45);

    tick(5);
    check(exp_q.size() == 0, "R6 pending steps", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule